// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the register file of an interrupt distributor that serves up to eight CPUs. Software reaches it through a single-cycle 32-bit bus with a 4 KB address window. The low two address bits select a byte lane. The block stores, for every interrupt ID, an enable bit, a pending-state bit, an 8-bit priority, a target CPU and a trigger mode. IDs 0 to 31 are private: each CPU has its own copy. IDs from 32 upward are shared by all CPUs.

Hardware interrupt lines feed the pending state every cycle. Each CPU has 16 private lines, for IDs 16 to 31. Each shared ID has one line. The block drives one pending flag per CPU. A flag is raised when some interrupt routed to that CPU is both pending and enabled, and the global enable is on.

A write to the software-interrupt word is not decoded here. It is passed on, one cycle later, as a strobe that carries the written word and the writing CPU. Priority arbitration, delivery queues and security grouping belong to other blocks.

Top module: `intdist_regs`

## Requirements
- R1: After reset, the following hold. The global enable is 0. The enable word at 0x100 reads 0x0000FFFF for every CPU. All pending bits are 0. Every shared target is CPU 0, so target bytes read 0x01. Every shared ID is level-triggered. No CPU pending flag is raised.
- R2: Address bits [1:0] give a byte offset k.
  - On a write, the data is masked to its low 32-8k bits and shifted left by 8k bits before it is applied.
  - On a read, the word is shifted right by 8k bits.
- R3: The control word at 0x000 is read/write. Bit 0 is the global enable.
  - 0x004 reads ((NCPU-1)<<5) | (NIRQ/32-1).
  - 0x008 reads 0x4B00043B.
  - Writes to 0x004 and 0x008 have no effect.
- R4: The following read as zero and ignore writes:
  - the regions at 0x080, 0x300 and 0x380;
  - bitmap words beyond the last implemented ID.
- R5: Writes to 0x100 and 0x200 set the bits given by the written ones. Writes to 0x180 and 0x280 clear them.
  - 0x100 and 0x180 act on the enable bits; 0x200 and 0x280 act on the pending bits.
  - Word 0 of each of these regions is private to the requesting CPU.
  - Enable bits 0 to 15 of word 0 always stay 1.
- R6: The priority region at 0x400 holds one byte per ID, with ID n at byte n. A write replaces the written bytes. Priorities of IDs 0 to 31 are private to each CPU.
- R7: For IDs 0 to 31, a target byte reads as the one-hot bit of the requesting CPU. Writes to these bytes are ignored.
- R8: A target byte of a shared ID (region 0x800, ID n at byte n) keeps only the lowest set bit among the implemented CPUs. If no such bit is set, the target is CPU 0. The byte reads back as the one-hot bit of the chosen CPU.
- R9: The configuration region at 0xC00 uses two bits per ID. For ID n, bit 2(n mod 16)+1 of word n/16 is 1 for edge trigger and 0 for level.
  - The low bit of each pair reads 0.
  - Words 0 and 1 read 0xAAAAAAAA, and writes to them are ignored.
- R10: Line inputs are applied every cycle.
  - A private line (IDs 16 to 31) is edge-triggered: a high line sets the pending bit.
  - A shared edge-triggered ID sets its pending bit while its line is high, and the bit stays set after the line drops.
  - A shared level-triggered ID's pending bit follows its line.
- R11: A CPU's flag is raised when the global enable is 1 and either of the following holds:
  - one of its private IDs is pending and enabled;
  - a shared ID targeted at it is pending and enabled.
- R12: A write to 0xF00 raises swi_wr for one cycle on the next cycle. swi_word then carries the shifted written word and swi_src carries the writing CPU. 0xF00 reads as zero.
- R13: bus_rdata carries the read result in the cycle after a read. In all other cycles it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPUW | Requesting CPU, which selects the private copies |
| banked_line | input | NCPU*16 | Private lines; bit c*16+k drives ID 16+k of CPU c |
| shared_line | input | NIRQ-32 | Shared lines; bit i drives ID 32+i |
| bus_rdata | output | 32 | Registered read data |
| cpu_pending | output | NCPU | Per-CPU pending flag |
| swi_wr | output | 1 | Software-interrupt word written |
| swi_word | output | 32 | Shifted word of that write |
| swi_src | output | CPUW | CPU that wrote it |

## Verification
The assertions check these rules on every cycle:
- Enable bits 0 to 15 of every CPU's private word stay set.
- A shared edge-triggered pending bit holds while no pending-region write occurs.
- A shared level-triggered bit equals its line one cycle later.
- The software-interrupt strobe follows only a write to its word.
- Read data is zero outside the cycle after a read.

The bench scenarios cover the rest: byte-lane shifting, the read-only and read-as-zero regions, private versus shared copies, target reduction, configuration expansion, flag routing and gating, and the effect of reset on stored state.

// File: rtl/intdist_regs.sv
module intdist_regs #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [CPUW-1:0]      bus_cpu,
  input  logic [NCPU*16-1:0]   banked_line,
  input  logic [NIRQ-33:0]     shared_line,
  output logic [31:0]          bus_rdata,
  output logic [NCPU-1:0]      cpu_pending,
  output logic                 swi_wr,
  output logic [31:0]          swi_word,
  output logic [CPUW-1:0]      swi_src
);
  localparam int NSPI = NIRQ - 32;
  localparam int NW   = NIRQ / 32;
  localparam logic [31:0] TYPE_VAL = 32'(((NCPU - 1) << 5) | (NW - 1));
  localparam logic [31:0] ID_VAL   = 32'h4B00043B;

  typedef enum logic [1:0] {W_IGN, W_SET, W_CLR, W_VAL} wmode_t;

  logic            gen;
  logic [31:0]     bst [NCPU];
  logic [31:0]     ben [NCPU];
  logic [31:0]     bst_n [NCPU];
  logic [NSPI-1:0] sst, sen, scfg, sst_n;
  logic [7:0]      bpri [NCPU][32];
  logic [7:0]      spri [NSPI];
  logic [CPUW-1:0] stgt [NSPI];

  logic [4:0]  shift;
  logic [31:0] mask, dsh, cur, nxt;
  logic        rd_en, wr;
  wmode_t      wmode;
  int          widx, pidx, cidx;

  assign shift = {bus_addr[1:0], 3'b000};
  assign mask  = 32'hFFFF_FFFF >> shift;
  assign dsh   = (bus_wdata & mask) << shift;
  assign widx  = int'(bus_addr[6:2]);
  assign pidx  = int'(bus_addr[9:2]);
  assign cidx  = int'(bus_addr[7:2]);
  assign wr    = bus_valid && bus_write;

  wire is_ctrl = bus_addr[11:7] == 5'd0;
  wire is_sen  = bus_addr[11:7] == 5'd2;
  wire is_cen  = bus_addr[11:7] == 5'd3;
  wire is_spd  = bus_addr[11:7] == 5'd4;
  wire is_cpd  = bus_addr[11:7] == 5'd5;
  wire is_pri  = bus_addr[11:10] == 2'b01;
  wire is_tgt  = bus_addr[11:10] == 2'b10;
  wire is_cfg  = bus_addr[11:8] == 4'hC;
  wire is_swi  = bus_addr[11:2] == 10'h3C0;
  wire bm_ok   = widx < NW;
  wire en_rgn  = is_sen || is_cen;
  wire pd_rgn  = is_spd || is_cpd;
  wire pend_wr = wr && pd_rgn;

  function automatic logic [CPUW-1:0] pick_cpu(input logic [7:0] b);
    pick_cpu = '0;
    for (int n = NCPU - 1; n >= 0; n--)
      if (b[n]) pick_cpu = CPUW'(n);
  endfunction

  always_comb begin
    cur = '0; rd_en = 1'b0; wmode = W_IGN;
    if (is_ctrl) begin
      rd_en = (widx < 3);
      if (widx == 0) begin cur = {31'b0, gen}; wmode = W_VAL; end
      if (widx == 1) cur = TYPE_VAL;
      if (widx == 2) cur = ID_VAL;
    end else if ((en_rgn || pd_rgn) && bm_ok) begin
      rd_en = 1'b1;
      wmode = (is_sen || is_spd) ? W_SET : W_CLR;
      if (widx == 0) cur = en_rgn ? ben[bus_cpu] : bst[bus_cpu];
      for (int k = 0; k < NW - 1; k++)
        if (widx == k + 1) cur = en_rgn ? sen[k*32 +: 32] : sst[k*32 +: 32];
    end else if (is_pri && pidx < NIRQ / 4) begin
      rd_en = 1'b1; wmode = W_VAL;
      for (int k = 0; k < 8; k++)
        if (pidx == k)
          for (int i = 0; i < 4; i++) cur[i*8 +: 8] = bpri[bus_cpu][k*4+i];
      for (int k = 8; k < NIRQ / 4; k++)
        if (pidx == k)
          for (int i = 0; i < 4; i++) cur[i*8 +: 8] = spri[k*4+i-32];
    end else if (is_tgt && pidx < NIRQ / 4) begin
      rd_en = 1'b1;
      if (pidx < 8) cur = {4{8'd1 << bus_cpu}};
      else wmode = W_VAL;
      for (int k = 8; k < NIRQ / 4; k++)
        if (pidx == k)
          for (int i = 0; i < 4; i++) cur[i*8 +: 8] = 8'd1 << stgt[k*4+i-32];
    end else if (is_cfg && cidx < NIRQ / 16) begin
      rd_en = 1'b1;
      if (cidx < 2) cur = 32'hAAAA_AAAA;
      else wmode = W_VAL;
      for (int k = 2; k < NIRQ / 16; k++)
        if (cidx == k)
          for (int j = 0; j < 16; j++) cur[2*j+1] = scfg[k*16+j-32];
    end else if (is_swi) begin
      wmode = W_VAL;
    end
  end

  always_comb begin
    case (wmode)
      W_SET:   nxt = cur | dsh;
      W_CLR:   nxt = cur & ~dsh;
      W_VAL:   nxt = (cur & ~(mask << shift)) | dsh;
      default: nxt = cur;
    endcase
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++)
      bst_n[c] = bst[c] | {banked_line[c*16 +: 16], 16'b0};
    sst_n = (scfg & (sst | shared_line)) | (~scfg & shared_line);
    if (pend_wr && bm_ok) begin
      if (widx == 0)
        bst_n[bus_cpu] = is_spd ? (bst_n[bus_cpu] | dsh) : (bst_n[bus_cpu] & ~dsh);
      for (int k = 0; k < NW - 1; k++)
        if (widx == k + 1)
          sst_n[k*32 +: 32] = is_spd ? (sst_n[k*32 +: 32] | dsh) : (sst_n[k*32 +: 32] & ~dsh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen <= 1'b0; sst <= '0; sen <= '0; scfg <= '0;
      bus_rdata <= '0; swi_wr <= 1'b0; swi_word <= '0; swi_src <= '0;
      for (int c = 0; c < NCPU; c++) begin
        bst[c] <= '0; ben[c] <= 32'h0000_FFFF;
        for (int i = 0; i < 32; i++) bpri[c][i] <= '0;
      end
      for (int i = 0; i < NSPI; i++) begin spri[i] <= '0; stgt[i] <= '0; end
    end else begin
      bst <= bst_n;
      sst <= sst_n;
      bus_rdata <= (bus_valid && !bus_write && rd_en) ? ((cur >> shift) & mask) : '0;
      swi_wr   <= wr && is_swi;
      swi_word <= dsh;
      swi_src  <= bus_cpu;
      if (wr) begin
        if (is_ctrl && widx == 0) gen <= nxt[0];
        if (en_rgn && bm_ok) begin
          if (widx == 0) ben[bus_cpu] <= nxt | 32'h0000_FFFF;
          for (int k = 0; k < NW - 1; k++)
            if (widx == k + 1) sen[k*32 +: 32] <= nxt;
        end
        if (is_pri) begin
          for (int k = 0; k < 8; k++)
            if (pidx == k)
              for (int i = 0; i < 4; i++) bpri[bus_cpu][k*4+i] <= nxt[i*8 +: 8];
          for (int k = 8; k < NIRQ / 4; k++)
            if (pidx == k)
              for (int i = 0; i < 4; i++) spri[k*4+i-32] <= nxt[i*8 +: 8];
        end
        if (is_tgt)
          for (int k = 8; k < NIRQ / 4; k++)
            if (pidx == k)
              for (int i = 0; i < 4; i++) stgt[k*4+i-32] <= pick_cpu(nxt[i*8 +: 8]);
        if (is_cfg)
          for (int k = 2; k < NIRQ / 16; k++)
            if (cidx == k)
              for (int j = 0; j < 16; j++) scfg[k*16+j-32] <= nxt[2*j+1];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      logic [NSPI-1:0] tm;
      for (int i = 0; i < NSPI; i++) tm[i] = (int'(stgt[i]) == c);
      cpu_pending[c] = gen && ((|(bst[c] & ben[c])) || (|(sst & sen & tm)));
    end
  end

  genvar gc, gi;
  generate
    for (gc = 0; gc < NCPU; gc++) begin : g_cpu_chk
      p_swi_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ben[gc][15:0] == 16'hFFFF);
    end
    for (gi = 0; gi < NSPI; gi++) begin : g_spi_chk
      p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sst[gi] && scfg[gi] && !pend_wr) |=> sst[gi]);
      p_level_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!scfg[gi] && !pend_wr) |=> (sst[gi] == $past(shared_line[gi])));
    end
  endgenerate

  p_swi_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    swi_wr |-> $past(bus_valid && bus_write && bus_addr[11:2] == 10'h3C0));
  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && !bus_write) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/intdist_regs_tb.sv
module intdist_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [63:0] banked_line = '0;
  logic [31:0] shared_line = '0;
  logic [31:0] bus_rdata, swi_word;
  logic [3:0]  cpu_pending;
  logic        swi_wr;
  logic [1:0]  swi_src;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intdist_regs #(.NCPU(4), .NIRQ(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .banked_line(banked_line), .shared_line(shared_line),
    .bus_rdata(bus_rdata), .cpu_pending(cpu_pending),
    .swi_wr(swi_wr), .swi_word(swi_word), .swi_src(swi_src));

  // {write, check, cpu, req, addr, wdata, expected}
  localparam int NV = 40;
  localparam logic [83:0] VEC [NV] = '{
    {1'b0,1'b1,2'd0,4'd1, 12'h000,32'h0,32'h0},              // R1 control
    {1'b0,1'b1,2'd0,4'd1, 12'h100,32'h0,32'h0000FFFF},       // R1 enables
    {1'b0,1'b1,2'd0,4'd3, 12'h004,32'h0,32'h00000061},       // R3 type
    {1'b1,1'b0,2'd0,4'd3, 12'h008,32'h0,32'h0},
    {1'b0,1'b1,2'd0,4'd3, 12'h008,32'h0,32'h4B00043B},       // R3 id
    {1'b1,1'b0,2'd0,4'd3, 12'h004,32'hFFFFFFFF,32'h0},
    {1'b0,1'b1,2'd0,4'd3, 12'h004,32'h0,32'h00000061},       // R3
    {1'b1,1'b0,2'd0,4'd4, 12'h080,32'hFFFFFFFF,32'h0},
    {1'b0,1'b1,2'd0,4'd4, 12'h080,32'h0,32'h0},              // R4 group
    {1'b1,1'b0,2'd0,4'd5, 12'h104,32'h5,32'h0},
    {1'b0,1'b1,2'd0,4'd5, 12'h104,32'h0,32'h5},              // R5 set
    {1'b1,1'b0,2'd0,4'd5, 12'h184,32'h1,32'h0},
    {1'b0,1'b1,2'd0,4'd5, 12'h104,32'h0,32'h4},              // R5 clear
    {1'b1,1'b0,2'd1,4'd5, 12'h180,32'hFFFFFFFF,32'h0},
    {1'b0,1'b1,2'd1,4'd5, 12'h100,32'h0,32'h0000FFFF},       // R5 forced
    {1'b1,1'b0,2'd2,4'd5, 12'h100,32'h00010000,32'h0},
    {1'b0,1'b1,2'd2,4'd5, 12'h100,32'h0,32'h0001FFFF},       // R5
    {1'b0,1'b1,2'd0,4'd5, 12'h100,32'h0,32'h0000FFFF},       // R5 private
    {1'b1,1'b0,2'd0,4'd6, 12'h404,32'h11223344,32'h0},
    {1'b0,1'b1,2'd0,4'd6, 12'h404,32'h0,32'h11223344},       // R6
    {1'b0,1'b1,2'd1,4'd6, 12'h404,32'h0,32'h0},              // R6 private
    {1'b1,1'b0,2'd0,4'd2, 12'h422,32'h0000AABB,32'h0},
    {1'b0,1'b1,2'd0,4'd2, 12'h420,32'h0,32'hAABB0000},       // R2 write shift
    {1'b0,1'b1,2'd0,4'd2, 12'h423,32'h0,32'h000000AA},       // R2 read shift
    {1'b0,1'b1,2'd2,4'd7, 12'h800,32'h0,32'h04040404},       // R7
    {1'b1,1'b0,2'd2,4'd7, 12'h800,32'h0,32'h0},
    {1'b0,1'b1,2'd2,4'd7, 12'h800,32'h0,32'h04040404},       // R7 ignored
    {1'b1,1'b0,2'd0,4'd8, 12'h820,32'h0006800C,32'h0},
    {1'b0,1'b1,2'd0,4'd8, 12'h820,32'h0,32'h01020104},       // R8
    {1'b0,1'b1,2'd0,4'd9, 12'hC00,32'h0,32'hAAAAAAAA},       // R9
    {1'b1,1'b0,2'd0,4'd9, 12'hC04,32'h0,32'h0},
    {1'b0,1'b1,2'd0,4'd9, 12'hC04,32'h0,32'hAAAAAAAA},       // R9 ignored
    {1'b0,1'b1,2'd0,4'd9, 12'hC08,32'h0,32'h0},              // R9 level
    {1'b1,1'b0,2'd0,4'd9, 12'hC08,32'h3,32'h0},
    {1'b0,1'b1,2'd0,4'd9, 12'hC08,32'h0,32'h2},              // R9 low bit
    {1'b1,1'b0,2'd0,4'd4, 12'h108,32'hFFFFFFFF,32'h0},
    {1'b0,1'b1,2'd0,4'd4, 12'h108,32'h0,32'h0},              // R4 range
    {1'b1,1'b0,2'd0,4'd3, 12'h000,32'h1,32'h0},
    {1'b0,1'b1,2'd0,4'd3, 12'h000,32'h0,32'h1},              // R3 enable
    {1'b0,1'b1,2'd0,4'd4, 12'h300,32'h0,32'h0}               // R4 active
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; bus_cpu = c;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 pending", {28'b0, cpu_pending}, 32'h0);
    for (int v = 0; v < NV; v++) begin
      bus(VEC[v][83], VEC[v][75:64], VEC[v][63:32], VEC[v][81:80]);
      if (VEC[v][82]) check($sformatf("R%0d vector %0d", VEC[v][79:76], v), bus_rdata, VEC[v][31:0]);
    end
    // R10 / R11: shared level ID 34, enabled, targeted at CPU 1
    @(negedge clk); shared_line[2] = 1'b1;
    @(negedge clk); check("R11 level routed", {28'b0, cpu_pending}, 32'h2);
    bus(1'b0, 12'h204, 32'h0, 2'd0); check("R10 level state", bus_rdata, 32'h4);
    @(negedge clk); shared_line[2] = 1'b0;
    @(negedge clk); check("R10 level follows", {28'b0, cpu_pending}, 32'h0);
    // R10: shared edge ID 32 targeted at CPU 2
    bus(1'b1, 12'h104, 32'h1, 2'd0);
    @(negedge clk); shared_line[0] = 1'b1;
    @(negedge clk); shared_line[0] = 1'b0;
    @(negedge clk); check("R10 edge held", {28'b0, cpu_pending}, 32'h4);
    bus(1'b0, 12'h204, 32'h0, 2'd0); check("R10 edge state", bus_rdata, 32'h1);
    bus(1'b1, 12'h284, 32'h1, 2'd0); check("R5 clear pending", {28'b0, cpu_pending}, 32'h0);
    // R10: private line of CPU 3, ID 16
    bus(1'b1, 12'h100, 32'h00010000, 2'd3);
    @(negedge clk); banked_line[48] = 1'b1;
    @(negedge clk); banked_line[48] = 1'b0;
    check("R11 private routed", {28'b0, cpu_pending}, 32'h8);
    bus(1'b0, 12'h200, 32'h0, 2'd3); check("R10 private latch", bus_rdata, 32'h00010000);
    bus(1'b0, 12'h200, 32'h0, 2'd0); check("R10 private copy", bus_rdata, 32'h0);
    // R11: global enable gating
    bus(1'b1, 12'h000, 32'h0, 2'd0); check("R11 gated off", {28'b0, cpu_pending}, 32'h0);
    bus(1'b1, 12'h000, 32'h1, 2'd0); check("R11 gated on", {28'b0, cpu_pending}, 32'h8);
    bus(1'b1, 12'h200, 32'h1, 2'd0); check("R5 set pending", {28'b0, cpu_pending}, 32'h9);
    // R12: software-interrupt word, byte offset 1
    bus(1'b1, 12'hF01, 32'h00000012, 2'd2);
    check("R12 strobe", {31'b0, swi_wr}, 32'h1);
    check("R12 word", swi_word, 32'h00001200);
    check("R12 source", {30'b0, swi_src}, 32'h2);
    @(negedge clk); check("R12 one cycle", {31'b0, swi_wr}, 32'h0);
    bus(1'b0, 12'hF00, 32'h0, 2'd0); check("R12 reads zero", bus_rdata, 32'h0);
    // R13: read data only in the cycle after a read
    bus(1'b0, 12'h008, 32'h0, 2'd0); check("R13 read", bus_rdata, 32'h4B00043B);
    @(negedge clk); check("R13 idle", bus_rdata, 32'h0);
    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 flags after reset", {28'b0, cpu_pending}, 32'h0);
    bus(1'b0, 12'h000, 32'h0, 2'd0); check("R1 control after reset", bus_rdata, 32'h0);
    bus(1'b0, 12'h104, 32'h0, 2'd0); check("R1 shared enables", bus_rdata, 32'h0);
    bus(1'b0, 12'h820, 32'h0, 2'd0); check("R1 targets", bus_rdata, 32'h01010101);
    bus(1'b0, 12'hC08, 32'h0, 2'd0); check("R1 trigger", bus_rdata, 32'h0);
    bus(1'b0, 12'h200, 32'h0, 2'd3); check("R1 private pending", bus_rdata, 32'h0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule